// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of an 8051-style multiplexed external memory bus. One is the address-latch enable (`ale`, active high), which tells an external latch to capture the low address byte. The other is the program-store enable (`psen_n`, active low), which is the read strobe for external code memory. The block runs on the oscillator-rate clock. Each machine cycle is twelve oscillator periods, grouped into six states of two periods each. The core's timing generator supplies the current phase (0 to 11) on `cyc_phase`, advancing it by one every clock.

At the start of each machine cycle, the core reports four things: whether code is being executed from external program memory, whether the cycle is an external data transfer, whether it is a code-table read, and whether the ALE-restrict control bit is set. The block latches these when the phase is 0. It then shapes the strobes for the whole cycle: it skips the pulses a data transfer forbids, and releases the ALE pad to its weak pull-up when restrict mode leaves nothing to latch.

All pins are plain control signals. No data moves through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst` is high, and on the clock after it is sampled high, `ale` is 0, `psen_n` is 1 and `ale_drive` is 1.
- R2: Outputs are registered. After the edge that samples phase p, they show the strobe for phase p. With no data transfer and restrict mode inactive, `ale` is high after phases 0,1 (state 1) and 6,7 (state 4), and low after every other phase. This gives two pulses, each two clocks wide, per twelve clocks: one sixth of the oscillator rate.
- R3: In a data-transfer cycle (`data_xfer`=1), the state-1 ALE pulse (phases 0,1) is skipped and the state-4 pulse (phases 6,7) is kept.
- R4: In a cycle with `fetch_ext`=1 or `table_rd`=1 and `data_xfer`=0, `psen_n` is 0 after phases 2..5 and 8..11, and 1 after phases 0,1,6,7. This gives two reads per machine cycle. With both flags 0, `psen_n` stays 1.
- R5: In a data-transfer cycle, `psen_n` stays 1 for all twelve phases, so both code reads are skipped.
- R6: With `ale_restrict`=1, `fetch_ext`=0, `data_xfer`=0 and `table_rd`=0, `ale` stays 0 and `ale_drive` is 0 for the whole cycle, releasing the pad to its weak high.
- R7: With `ale_restrict`=1, `fetch_ext`=0 and either `data_xfer` or `table_rd` set, `ale_drive` is 1 and `ale` pulses as in R2 and R3.
- R8: With `fetch_ext`=1, `ale_restrict` has no effect: `ale` and `ale_drive` match the unrestricted case.
- R9: `fetch_ext`, `data_xfer`, `table_rd` and `ale_restrict` are taken on the edge where `cyc_phase` is 0 and held for phases 1..11. Changes during phases 1..11 have no effect until the next phase 0.
- R10: A `cyc_phase` value of 12 or more gives `ale`=0 and `psen_n`=1.
- R11: `ale`=1 and `psen_n`=0 never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_phase | input | PHASE_W (4) | Oscillator phase within the machine cycle, 0..11 |
| fetch_ext | input | 1 | Core is executing from external program memory |
| data_xfer | input | 1 | This cycle is an external data transfer |
| table_rd | input | 1 | This cycle reads a code table from external code space |
| ale_restrict | input | 1 | ALE-restrict control bit |
| ale | output | 1 | Address-latch enable strobe, active high |
| ale_drive | output | 1 | 1: pad drives `ale`; 0: pad released to weak pull-up |
| psen_n | output | 1 | Code read strobe, active low |

## Verification
Each strobe value is due exactly one clock after the edge that samples its phase. There is a single register stage and no other delay. The bench's reference model updates on the rising edge from the phase and flags it sees there, and compares on the following falling edge. The flag capture is checked the same way. After a cycle's flags are changed mid-cycle, the model keeps the values taken at phase 0, and any mismatch in that cycle is reported against R9.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  // Per-cycle control taken at the start of a machine cycle
  typedef struct packed {
    logic fetch_ext;
    logic data_xfer;
    logic table_rd;
    logic restrict_on;
  } cyc_flags_t;

  localparam int STATES_PER_CYCLE = 6;

  // True when phase lies in the given state (1-based) of STATE_LEN phases
  function automatic logic in_state(input int phase, input int state, input int state_len);
    return (phase >= (state - 1) * state_len) && (phase < state * state_len);
  endfunction

endpackage

// File: rtl/bsg_cycle_latch.sv
module bsg_cycle_latch
  import bsg_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase,
  input  cyc_flags_t         flags_in,
  output cyc_flags_t         flags_eff
);

  cyc_flags_t held;
  logic       at_start;

  assign at_start  = (phase == '0);
  assign flags_eff = at_start ? flags_in : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (at_start) begin
      held <= flags_in;
    end
  end

  // R9: held flags only move on a phase-0 edge
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |=> $stable(held));

endmodule

// File: rtl/bsg_ale_gen.sv
module bsg_ale_gen
  import bsg_pkg::*;
#(
  parameter int PHASE_W   = 4,
  parameter int STATE_LEN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase,
  input  cyc_flags_t         flags,
  output logic               ale,
  output logic               ale_drive
);

  localparam int CYCLE_LEN = STATES_PER_CYCLE * STATE_LEN;
  localparam int LATCH_A   = 1;  // first address latch state
  localparam int LATCH_B   = 4;  // second address latch state

  logic in_range, slot_a, slot_b, released, ale_d;

  always_comb begin
    in_range = int'(phase) < CYCLE_LEN;
    slot_a   = in_state(int'(phase), LATCH_A, STATE_LEN);
    slot_b   = in_state(int'(phase), LATCH_B, STATE_LEN);
    released = flags.restrict_on && !flags.fetch_ext && !(flags.data_xfer || flags.table_rd);
    ale_d    = in_range && !released && ((slot_a && !flags.data_xfer) || slot_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale       <= 1'b0;
      ale_drive <= 1'b1;
    end else begin
      ale       <= ale_d;
      ale_drive <= !released;
    end
  end

  // R6: a released pad never carries a pulse
  assert_released_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !ale_drive |-> !ale);

  // R3: no state-1 pulse in a data-transfer cycle
  assert_data_skip_s1_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(flags.data_xfer) && (int'($past(phase)) < STATE_LEN)) |-> !ale);

  // R10: out-of-range phase yields no pulse
  assert_range_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (int'($past(phase)) >= CYCLE_LEN) |-> !ale);

endmodule

// File: rtl/bsg_psen_gen.sv
module bsg_psen_gen
  import bsg_pkg::*;
#(
  parameter int PHASE_W   = 4,
  parameter int STATE_LEN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase,
  input  logic               fetch_ext,
  input  logic               data_xfer,
  input  logic               table_rd,
  output logic               psen_n
);

  localparam int CYCLE_LEN = STATES_PER_CYCLE * STATE_LEN;

  // Read windows: states 2-3 and 5-6, clear of both latch states
  localparam int NWIN = 4;
  localparam int READ_STATES [NWIN] = '{2, 3, 5, 6};

  logic [NWIN-1:0] hit;
  logic            in_range, read_cyc, psen_d;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit[g] = in_state(int'(phase), READ_STATES[g], STATE_LEN);
  end

  always_comb begin
    in_range = int'(phase) < CYCLE_LEN;
    read_cyc = (fetch_ext || table_rd) && !data_xfer;
    psen_d   = !(in_range && read_cyc && (|hit));
  end

  always_ff @(posedge clk) begin
    if (rst) psen_n <= 1'b1;
    else     psen_n <= psen_d;
  end

  // R5: data-transfer cycles suppress code reads
  assert_data_no_read_R5: assert property (@(posedge clk) disable iff (rst)
    $past(data_xfer) |-> psen_n);

  // R4: no read without an external code reason
  assert_read_reason_R4: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> ($past(fetch_ext) || $past(table_rd)));

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int STATE_LEN = 2,
  parameter int PHASE_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] cyc_phase,
  input  logic               fetch_ext,
  input  logic               data_xfer,
  input  logic               table_rd,
  input  logic               ale_restrict,
  output logic               ale,
  output logic               ale_drive,
  output logic               psen_n
);

  cyc_flags_t flags_in, flags_eff;

  assign flags_in = '{fetch_ext: fetch_ext, data_xfer: data_xfer,
                      table_rd: table_rd, restrict_on: ale_restrict};

  bsg_cycle_latch #(.PHASE_W(PHASE_W)) u_latch (
    .clk(clk), .rst(rst), .phase(cyc_phase),
    .flags_in(flags_in), .flags_eff(flags_eff)
  );

  bsg_ale_gen #(.PHASE_W(PHASE_W), .STATE_LEN(STATE_LEN)) u_ale (
    .clk(clk), .rst(rst), .phase(cyc_phase), .flags(flags_eff),
    .ale(ale), .ale_drive(ale_drive)
  );

  bsg_psen_gen #(.PHASE_W(PHASE_W), .STATE_LEN(STATE_LEN)) u_psen (
    .clk(clk), .rst(rst), .phase(cyc_phase),
    .fetch_ext(flags_eff.fetch_ext), .data_xfer(flags_eff.data_xfer),
    .table_rd(flags_eff.table_rd), .psen_n(psen_n)
  );

  // R11: latch strobe and read strobe are never active together
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

endmodule

// File: tb/bus_strobe_gen_tb.sv
`timescale 1ns/1ps
module bus_strobe_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cyc_phase = '0;
  logic       fetch_ext = 1'b0, data_xfer = 1'b0, table_rd = 1'b0, ale_restrict = 1'b0;
  logic       ale, ale_drive, psen_n;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bus_strobe_gen u_dut (
    .clk(clk), .rst(rst), .cyc_phase(cyc_phase),
    .fetch_ext(fetch_ext), .data_xfer(data_xfer), .table_rd(table_rd),
    .ale_restrict(ale_restrict),
    .ale(ale), .ale_drive(ale_drive), .psen_n(psen_n)
  );

  // Reference model state
  bit m_valid = 0;
  bit m_ale, m_drv, m_psen;
  bit h_ce, h_xd, h_xc, h_q;
  bit m_wiggled;
  bit m_rst;
  int m_phase;

  always @(posedge clk) begin
    bit ce, xd, xc, q, inr, rel;
    int st;
    m_valid = 1;
    m_rst   = rst;
    m_phase = int'(cyc_phase);
    if (rst) begin
      m_ale = 0; m_drv = 1; m_psen = 1;
      h_ce = 0; h_xd = 0; h_xc = 0; h_q = 0; m_wiggled = 0;
    end else begin
      if (cyc_phase == 0) begin
        h_ce = fetch_ext; h_xd = data_xfer; h_xc = table_rd; h_q = ale_restrict;
        m_wiggled = 0;
      end else if ({fetch_ext, data_xfer, table_rd, ale_restrict} != {h_ce, h_xd, h_xc, h_q}) begin
        m_wiggled = 1;
      end
      ce = h_ce; xd = h_xd; xc = h_xc; q = h_q;
      inr = m_phase < 12;
      st  = m_phase / 2 + 1;
      rel = q && !ce && !(xd || xc);
      m_ale  = inr && !rel && ((st == 1 && !xd) || st == 4);
      m_drv  = !rel;
      m_psen = !(inr && (ce || xc) && !xd && (st == 2 || st == 3 || st == 5 || st == 6));
    end
  end

  function automatic string tag_ale();
    if (m_rst) return "R1";
    if (m_wiggled) return "R9";
    if (m_phase >= 12) return "R10";
    if (h_q && !h_ce && !(h_xd || h_xc)) return "R6";
    if (h_q && !h_ce) return "R7";
    if (h_q && h_ce) return "R8";
    if (h_xd) return "R3";
    return "R2";
  endfunction

  function automatic string tag_psen();
    if (m_rst) return "R1";
    if (m_wiggled) return "R9";
    if (m_phase >= 12) return "R10";
    if (h_xd) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (m_valid) begin
      checks++;
      if (ale !== m_ale || ale_drive !== m_drv) begin
        failures++;
        $display("FAIL %s phase=%0d ale/drive actual=%b%b expected=%b%b",
                 tag_ale(), m_phase, ale, ale_drive, m_ale, m_drv);
      end
      checks++;
      if (psen_n !== m_psen) begin
        failures++;
        $display("FAIL %s phase=%0d psen_n actual=%b expected=%b",
                 tag_psen(), m_phase, psen_n, m_psen);
      end
      checks++;
      if (ale === 1'b1 && psen_n === 1'b0) begin  // R11
        failures++;
        $display("FAIL R11 overlap actual=ale1_psen0 expected=no_overlap");
      end
    end
  end

  task automatic mcycle(input bit ce, input bit xd, input bit xc, input bit q, input bit wiggle);
    for (int i = 0; i < 12; i++) begin
      cyc_phase = 4'(i);
      if (i == 0) begin
        fetch_ext = ce; data_xfer = xd; table_rd = xc; ale_restrict = q;
      end else if (wiggle && i == 3) begin
        fetch_ext = !ce; data_xfer = !xd; table_rd = !xc; ale_restrict = !q;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;  // R1 explicit reset state
    if (ale !== 1'b0 || psen_n !== 1'b1 || ale_drive !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset actual=%b%b%b expected=011", ale, ale_drive, psen_n);
    end
    rst = 1'b0;
    mcycle(0, 0, 0, 0, 0);  // R2 internal execution
    mcycle(1, 0, 0, 0, 0);  // R2/R4 external fetch
    mcycle(1, 1, 0, 0, 0);  // R3/R5 data transfer during external execution
    mcycle(0, 1, 0, 0, 0);  // R3/R5 data transfer during internal execution
    mcycle(0, 0, 1, 0, 0);  // R4 table read
    mcycle(0, 0, 0, 1, 0);  // R6 released
    mcycle(0, 1, 0, 1, 0);  // R7 restrict with data transfer
    mcycle(0, 0, 1, 1, 0);  // R7 restrict with table read
    mcycle(1, 0, 0, 1, 0);  // R8 restrict overridden
    mcycle(1, 1, 0, 1, 0);  // R8 with data transfer
    mcycle(0, 0, 0, 1, 0);
    mcycle(0, 0, 0, 0, 1);  // R9 mid-cycle changes ignored
    mcycle(1, 0, 0, 0, 1);
    mcycle(0, 1, 1, 1, 1);
    for (int i = 12; i < 16; i++) begin  // R10 out-of-range phases
      cyc_phase = 4'(i);
      fetch_ext = 1; data_xfer = 0; table_rd = 1; ale_restrict = 0;
      @(negedge clk);
    end
    mcycle(1, 0, 0, 0, 0);
    for (int k = 0; k < 16; k++)
      mcycle(k[0], k[1], k[2], k[3], 0);
    cyc_phase = 4'd6;
    rst = 1'b1;  // R1 reset mid-run
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mcycle(1, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule